// File: doc/BRIEF.md
# Truncating Pipelined Multiply-Accumulate Unit

This block is a signed multiply-accumulate unit. Each clock cycle it can take two two's complement operands and multiply them. It keeps only the upper half of the product, which is the most significant byte at the default widths. It sign-extends that part to the accumulator width and adds it into a running two's complement sum. A register stage sits between the multiplier and the adder, so the two arithmetic paths are timed separately. The valid and clear strobes go through that stage with the operands.

To start a fresh sum, assert the clear strobe together with the first valid operand pair. The sum then begins with that pair's term and no idle cycle is needed. A sticky flag records any signed overflow of the running sum until the next clear.

Top module: `trunc_mac`

## Requirements
- R1: After a cycle with rst_n low at a rising edge, acc_o reads 0 and ovf_o reads 0.
- R2: The term for an operand pair is bits [15:8] of the signed 16-bit product a_i*b_i. It is sign-extended to 16 bits and added modulo 2^16. Because the lower product bits are dropped, the term is the floor of product/256.
- R3: The term from operands presented with vld_i high before rising edge k appears on acc_o after edge k+1, and not after edge k.
- R4: A pair presented with vld_i low and clr_i low leaves acc_o and ovf_o unchanged.
- R5: clr_i high together with vld_i high loads acc_o with that pair's term alone and clears ovf_o.
- R6: clr_i high with vld_i low loads acc_o with 0 and clears ovf_o.
- R7: ovf_o is set when the previous sum and the term have the same sign bit (bit 15) and the new sum's bit 15 differs from it. The sum wraps modulo 2^16.
- R8: Once set, ovf_o stays high through further accumulation until a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_i | input | 1 | Start a new sum with this cycle's pair |
| vld_i | input | 1 | Operand pair is valid this cycle |
| a_i | input | 8 | First operand, two's complement |
| b_i | input | 8 | Second operand, two's complement |
| acc_o | output | 16 | Running sum, two's complement |
| ovf_o | output | 1 | Sticky signed overflow flag |

## Verification
The operand patterns mix signs to expose specific faults:
- A positive and a negative product of equal size reveal whether truncation floors.
- A product that is small or is -1 shows whether low product bits are wrongly kept.
- The most negative squared shows whether sign extension of the term is correct.

Long runs of the largest positive term, and of a negative term, drive the sum past each end of the range. The bench checks that the result exactly at the limit raises no flag and that the next term does raise it. A clear with a valid pair and a clear without one tell apart "load term" from "load zero". A single-step observation after one edge confirms the two-cycle latency.

// File: rtl/mac_pkg.sv
// Package: default widths shared by the multiply-accumulate blocks.
// Assumes: the accumulator is at least as wide as one operand.
package mac_pkg;
    localparam int DEF_OP_W  = 8;
    localparam int DEF_ACC_W = 16;
endpackage

// File: rtl/mac_mul_stage.sv
// Module: signed multiplier with its output register stage.
// It keeps the upper OP_W bits of the product, sign-extends them to ACC_W,
// and registers the result together with the valid and clear strobes.
// Assumes: ACC_W >= OP_W; synchronous active-low reset.
module mac_mul_stage #(
    parameter int OP_W  = mac_pkg::DEF_OP_W,
    parameter int ACC_W = mac_pkg::DEF_ACC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic             clr_i,
    input  logic [OP_W-1:0]  a_i,
    input  logic [OP_W-1:0]  b_i,
    output logic [ACC_W-1:0] term_o,
    output logic             vld_o,
    output logic             clr_o
);
    localparam int PROD_W = 2 * OP_W;
    localparam int EXT_W  = ACC_W - OP_W;

    logic signed [PROD_W-1:0] prod;
    logic [ACC_W-1:0]         term_d;

    // Full-width signed product of the two operands.
    assign prod = $signed(a_i) * $signed(b_i);

    // Keep the upper half of the product and sign-extend it.
    assign term_d = {{EXT_W{prod[PROD_W-1]}}, prod[PROD_W-1 -: OP_W]};

    // Pipeline register between multiplier and accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            term_o <= '0;
            vld_o  <= 1'b0;
            clr_o  <= 1'b0;
        end else begin
            term_o <= term_d;
            vld_o  <= vld_i;
            clr_o  <= clr_i;
        end
    end

    // R3: strobes reach the adder exactly one cycle after the inputs.
    a_r3_strobe_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (vld_o == $past(vld_i)) && (clr_o == $past(clr_i)));

    // R2: the registered term is always a sign extension of its own top byte.
    a_r2_term_sext: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (term_o[ACC_W-1:OP_W-1] == '0) || (term_o[ACC_W-1:OP_W-1] == '1));
endmodule

// File: rtl/mac_accum.sv
// Module: two's complement accumulator with a sticky overflow flag.
// A clear starts a new sum from the incoming term, or from zero when no
// term is valid. Otherwise a valid term is added and the flag is updated.
// Assumes: term_i is already sign-extended; synchronous active-low reset.
module mac_accum #(
    parameter int ACC_W = mac_pkg::DEF_ACC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic             clr_i,
    input  logic [ACC_W-1:0] term_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             ovf_o
);
    localparam int MSB = ACC_W - 1;

    logic [ACC_W-1:0] sum;
    logic             ovf_now;
    logic signed [ACC_W:0] wide_sum;

    // Wrapping sum of the running total and the new term.
    assign sum = acc_o + term_i;

    // Same-sign addends whose sum changes sign indicate overflow.
    assign ovf_now = (acc_o[MSB] == term_i[MSB]) && (sum[MSB] != acc_o[MSB]);

    // One-bit-wider exact sum, used only to check the overflow detection.
    assign wide_sum = $signed({acc_o[MSB], acc_o}) + $signed({term_i[MSB], term_i});

    // Accumulator and sticky flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_o <= '0;
            ovf_o <= 1'b0;
        end else if (clr_i) begin
            acc_o <= vld_i ? term_i : '0;
            ovf_o <= 1'b0;
        end else if (vld_i) begin
            acc_o <= sum;
            ovf_o <= ovf_o | ovf_now;
        end
    end

    // R4: with no strobe the state does not move.
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!vld_i && !clr_i) |=> $stable(acc_o) && $stable(ovf_o));

    // R6: a clear without a term yields an empty sum.
    a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !vld_i) |=> (acc_o == '0) && !ovf_o);

    // R5: a clear with a term yields that term and a clean flag.
    a_r5_clear_load: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && vld_i) |=> (acc_o == $past(term_i)) && !ovf_o);

    // R7: an out-of-range exact sum must raise the flag.
    a_r7_flag_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && !clr_i && (wide_sum[ACC_W] != wide_sum[MSB])) |=> ovf_o);

    // R8: the flag only drops through a clear.
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !clr_i) |=> ovf_o);
endmodule

// File: rtl/trunc_mac.sv
// Module: top of the truncating pipelined multiply-accumulate unit.
// It chains the multiplier stage and the accumulator. The result of an
// operand pair shows two rising edges after it is presented.
// Assumes: synchronous active-low reset; ACC_W >= OP_W.
module trunc_mac #(
    parameter int OP_W  = mac_pkg::DEF_OP_W,
    parameter int ACC_W = mac_pkg::DEF_ACC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             vld_i,
    input  logic [OP_W-1:0]  a_i,
    input  logic [OP_W-1:0]  b_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             ovf_o
);
    logic [ACC_W-1:0] term_q;
    logic             vld_q;
    logic             clr_q;

    // Multiply, truncate and register.
    mac_mul_stage #(.OP_W(OP_W), .ACC_W(ACC_W)) u_mul (
        .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .clr_i(clr_i),
        .a_i(a_i), .b_i(b_i),
        .term_o(term_q), .vld_o(vld_q), .clr_o(clr_q)
    );

    // Accumulate registered terms.
    mac_accum #(.ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .vld_i(vld_q), .clr_i(clr_q),
        .term_i(term_q), .acc_o(acc_o), .ovf_o(ovf_o)
    );

    // R1: reset empties the sum and lowers the flag.
    a_r1_reset: assert property (@(posedge clk)
        !rst_n |=> (acc_o == '0) && !ovf_o);
endmodule

// File: tb/sim_trunc_mac.sv
`timescale 1ns/1ps
module sim_trunc_mac;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_i = 1'b0;
    logic        vld_i = 1'b0;
    logic [7:0]  a_i = '0;
    logic [7:0]  b_i = '0;
    logic [15:0] acc_o;
    logic        ovf_o;
    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    trunc_mac u0 (.clk(clk), .rst_n(rst_n), .clr_i(clr_i), .vld_i(vld_i),
                  .a_i(a_i), .b_i(b_i), .acc_o(acc_o), .ovf_o(ovf_o));

    // {clr, vld, a, b, expected acc, expected ovf}; each row starts after the previous one.
    localparam logic [34:0] VEC [7] = '{
        {1'b1, 1'b1, 8'h64, 8'h64, 16'h0027, 1'b0}, // R5: 100*100 -> 39
        {1'b0, 1'b1, 8'h9C, 8'h64, 16'hFFFF, 1'b0}, // R2: -100*100 -> -40 (floor)
        {1'b0, 1'b1, 8'h80, 8'h80, 16'h003F, 1'b0}, // R2: -128*-128 -> 64
        {1'b0, 1'b1, 8'h03, 8'h05, 16'h003F, 1'b0}, // R2: 15 -> 0
        {1'b0, 1'b1, 8'hFF, 8'h01, 16'h003E, 1'b0}, // R2: -1 -> -1
        {1'b0, 1'b0, 8'h7F, 8'h7F, 16'h003E, 1'b0}, // R4: not valid, ignored
        {1'b1, 1'b0, 8'h00, 8'h00, 16'h0000, 1'b0}  // R6: clear to zero
    };

    task automatic check(input string req, input logic [15:0] acc_exp, input logic ovf_exp);
        n_chk++;
        if (acc_o !== acc_exp || ovf_o !== ovf_exp) begin
            n_bad++;
            $display("FAIL %s: acc=%h ovf=%b expected acc=%h ovf=%b",
                     req, acc_o, ovf_o, acc_exp, ovf_exp);
        end
    endtask

    task automatic drive(input logic c, input logic v, input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        clr_i = c; vld_i = v; a_i = a; b_i = b;
    endtask

    // Return to idle, let the pipeline drain, and stop at a falling edge.
    task automatic settle();
        drive(1'b0, 1'b0, 8'h00, 8'h00);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: acc=%h ovf=%b expected completion", acc_o, ovf_o);
        $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 16'h0000, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < 7; i++) begin
            drive(VEC[i][34], VEC[i][33], VEC[i][32:25], VEC[i][24:17]);
            settle();
            check("R2/R4/R5/R6 table", VEC[i][16:1], VEC[i][0]);
        end

        // R3: one edge is not enough, two edges are.
        drive(1'b1, 1'b1, 8'h64, 8'h64);
        drive(1'b0, 1'b0, 8'h00, 8'h00);
        check("R3 after one edge", 16'h0000, 1'b0);
        @(negedge clk);
        check("R3 after two edges", 16'h0027, 1'b0);

        // R7: positive overflow. 511*64 + 63 = 32767 exactly, then +64 wraps.
        drive(1'b1, 1'b0, 8'h00, 8'h00);
        for (int i = 0; i < 511; i++) drive(1'b0, 1'b1, 8'h80, 8'h80);
        drive(1'b0, 1'b1, 8'h7F, 8'h7F);
        settle();
        check("R7 at limit", 16'h7FFF, 1'b0);
        drive(1'b0, 1'b1, 8'h80, 8'h80);
        settle();
        check("R7 positive wrap", 16'h803F, 1'b1);

        // R8: flag holds through a zero term and an idle cycle.
        drive(1'b0, 1'b1, 8'h00, 8'h55);
        settle();
        check("R8 sticky", 16'h803F, 1'b1);
        drive(1'b1, 1'b1, 8'h64, 8'h64);
        settle();
        check("R8/R5 clear drops flag", 16'h0027, 1'b0);

        // R7: negative overflow. 512*(-64) = -32768 exactly, then -64 wraps.
        drive(1'b1, 1'b0, 8'h00, 8'h00);
        for (int i = 0; i < 512; i++) drive(1'b0, 1'b1, 8'h80, 8'h7F);
        settle();
        check("R7 at negative limit", 16'h8000, 1'b0);
        drive(1'b0, 1'b1, 8'h80, 8'h7F);
        settle();
        check("R7 negative wrap", 16'h7FC0, 1'b1);

        // R6: clear with no term also drops the flag.
        drive(1'b1, 1'b0, 8'h12, 8'h34);
        settle();
        check("R6 clear no term", 16'h0000, 1'b0);

        // R1: reset in mid-sum.
        drive(1'b0, 1'b1, 8'h7F, 8'h7F);
        settle();
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run", 16'h0000, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule